// File: doc/BRIEF.md
# Folded Three-Operand Adder

This block forms the sum of three two's-complement samples using a single two-input adder that is reused across two clock cycles per sample. The clock runs at twice the sample rate. In the first cycle of a sample the adder combines the first two operands, and the result is written into a feedback register. In the second cycle the adder combines that registered partial sum with the third operand.

The completed sum appears on the output in the cycle after the second one, with a one-cycle valid pulse. The source presents each sample (all three operands together) on the inputs for two consecutive clocks while raising the input-valid strobe for both. Between samples the strobe may drop for any number of cycles. The operand schedule resumes from its first step when the next sample arrives.

The output is two bits wider than the operands, so no combination of operand values can overflow. A two-stage synchronizer releases the active-low asynchronous reset on a clock edge.

Top module: `fold_add3`

## Requirements
- R1: After reset is released, `sum_valid` is 0 and `sum_out` is 0 until the first sample has been processed.
- R2: The operand-select phase starts at 0 after reset, advances on every clock where `in_valid` is 1, and holds while `in_valid` is 0. The first valid cycle after reset, or after an even number of valid cycles, is therefore always the first step of a sample.
- R3: After the clock edge that ends the first step (phase 0) of a sample, `sum_out` equals the sign-extended sum of `a_in` and `b_in`.
- R4: After the clock edge that ends the second step (phase 1) of a sample, `sum_out` equals the sign-extended sum `a_in + b_in + c_in`, the exact two's-complement value on W+2 bits.
- R5: `sum_valid` is 1 for exactly one clock per sample, the cycle that directly follows that sample's phase-1 cycle, and is 0 otherwise.
- R6: No overflow occurs: with all three operands at the most positive value, or all at the most negative value, the result is exact.
- R7: While `in_valid` is 0, `sum_out` keeps its value and `sum_valid` is 0 from the second idle cycle onward.
- R8: With samples sent back to back, the result of one sample is presented during the first step of the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | High during both cycles of each sample |
| a_in | input | W | First operand, two's complement |
| b_in | input | W | Second operand, two's complement |
| c_in | input | W | Third operand, two's complement |
| sum_out | output | W+2 | Feedback register: the partial sum after step 0, the full sum after step 1 |
| sum_valid | output | 1 | One-cycle pulse when `sum_out` holds a completed sum |

## Verification
The checker assumes that every sample arrives as two consecutive valid cycles with unchanged operands. Its result property rebuilds the full sum from the partial value of the previous cycle, so a sample split by an idle gap or changed between its two cycles would break that assumption. The bench keeps within it: its send task always drives a pair of valid cycles with fixed operands and inserts idle gaps only after a completed pair. Random gap lengths and back-to-back runs exercise the phase hold, and directed extreme operands exercise the width growth.

// File: rtl/fold_add_pkg.sv
package fold_add_pkg;
  // Operand-select step within one sample
  typedef enum logic {
    PH_AB = 1'b0,   // external first and second operands
    PH_CP = 1'b1    // fed-back partial sum and third operand
  } phase_e;
endpackage

// File: rtl/fold_add_rst_sync.sv
module fold_add_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fold_add_phase.sv
module fold_add_phase
  import fold_add_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  output phase_e phase
);
  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (advance) begin
      phase_d = (phase_q == PH_AB) ? PH_CP : PH_AB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AB;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/fold_add_opsel.sv
module fold_add_opsel
  import fold_add_pkg::*;
#(
  parameter int W     = 16,
  parameter int GROW  = 2,
  localparam int OW   = W + GROW,
  localparam int NOPS = 3
) (
  input  phase_e          phase,
  input  logic [W-1:0]    a_in,
  input  logic [W-1:0]    b_in,
  input  logic [W-1:0]    c_in,
  input  logic [OW-1:0]   fb_sum,
  output logic [OW-1:0]   lhs,
  output logic [OW-1:0]   rhs
);
  logic [NOPS-1:0][W-1:0]  raw;
  logic [NOPS-1:0][OW-1:0] ext;

  assign raw[0] = a_in;
  assign raw[1] = b_in;
  assign raw[2] = c_in;

  // sign-extend every operand to the output width
  for (genvar i = 0; i < NOPS; i++) begin : g_sext
    assign ext[i] = {{GROW{raw[i][W-1]}}, raw[i]};
  end

  always_comb begin
    if (phase == PH_AB) begin
      lhs = ext[0];
      rhs = ext[1];
    end else begin
      lhs = fb_sum;
      rhs = ext[2];
    end
  end
endmodule

// File: rtl/fold_add_core.sv
module fold_add_core
  import fold_add_pkg::*;
#(
  parameter int OW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  phase_e        phase,
  input  logic [OW-1:0] lhs,
  input  logic [OW-1:0] rhs,
  output logic [OW-1:0] acc,
  output logic          done
);
  logic [OW-1:0] sum_d;
  logic [OW-1:0] acc_q;
  logic          acc_en;
  logic          done_d;
  logic          done_q;

  // the single shared adder
  always_comb begin
    sum_d  = lhs + rhs;
    acc_en = in_valid;
    done_d = in_valid && (phase == PH_CP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign acc  = acc_q;
  assign done = done_q;
endmodule

// File: rtl/fold_add3.sv
module fold_add3
  import fold_add_pkg::*;
#(
  parameter int W          = 16,
  parameter int GROW       = 2,
  parameter int RST_STAGES = 2,
  localparam int OW        = W + GROW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  output logic [OW-1:0] sum_out,
  output logic          sum_valid
);
  logic          rst_sync_n;
  phase_e        phase_q;
  logic [OW-1:0] lhs;
  logic [OW-1:0] rhs;
  logic [OW-1:0] acc;
  logic          done;

  fold_add_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fold_add_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .advance (in_valid),
    .phase   (phase_q)
  );

  fold_add_opsel #(.W(W), .GROW(GROW)) u_opsel (
    .phase  (phase_q),
    .a_in   (a_in),
    .b_in   (b_in),
    .c_in   (c_in),
    .fb_sum (acc),
    .lhs    (lhs),
    .rhs    (rhs)
  );

  fold_add_core #(.OW(OW)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .phase    (phase_q),
    .lhs      (lhs),
    .rhs      (rhs),
    .acc      (acc),
    .done     (done)
  );

  assign sum_out   = acc;
  assign sum_valid = done;
endmodule

// File: rtl/fold_add3_chk.sv
module fold_add3_chk
  import fold_add_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          in_valid,
  input phase_e        phase_q,
  input logic [W-1:0]  a_in,
  input logic [W-1:0]  b_in,
  input logic [W-1:0]  c_in,
  input logic [OW-1:0] sum_out,
  input logic          sum_valid
);
  // R2
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> phase_q != $past(phase_q));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(phase_q));

  // R3
  partial_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && phase_q == PH_AB) |=>
      sum_out == ({{(OW-W){$past(a_in[W-1])}}, $past(a_in)}
                + {{(OW-W){$past(b_in[W-1])}}, $past(b_in)}));

  // R4
  result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && phase_q == PH_CP) |=>
      sum_out == ($past(sum_out) + {{(OW-W){$past(c_in[W-1])}}, $past(c_in)}));

  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sum_valid |-> ($past(in_valid) && $past(phase_q) == PH_CP));

  // R5
  pulse_gen_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && phase_q == PH_CP) |=> sum_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(sum_out));
endmodule

bind fold_add3 fold_add3_chk #(.W(W), .OW(OW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .phase_q    (phase_q),
  .a_in       (a_in),
  .b_in       (b_in),
  .c_in       (c_in),
  .sum_out    (sum_out),
  .sum_valid  (sum_valid)
);

// File: tb/fold_add3_tb.sv
module fold_add3_tb;
  localparam int W  = 16;
  localparam int OW = W + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  a_in, b_in, c_in;
  logic [OW-1:0] sum_out;
  logic          sum_valid;

  int total = 0;
  int bad   = 0;
  int sent  = 0;
  int seen  = 0;
  bit done_flag = 1'b0;
  logic [OW-1:0] expq[$];

  always #4 clk = ~clk;

  fold_add3 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_out(sum_out), .sum_valid(sum_valid)
  );

  function automatic logic [OW-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b,
                                            logic [W-1:0] c, bit use_c);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    if (use_c) s = s + longint'($signed(c));
    return OW'(s);
  endfunction

  task automatic check(string req, logic [OW-1:0] act, logic [OW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // result monitor: every pulse must carry the oldest pending sum (R4, R8)
  always @(posedge clk) begin
    #1;
    if (rst_n && sum_valid) begin
      seen++;
      if (expq.size() == 0) begin
        check("R5 spurious pulse", 1, 0);
      end else begin
        check("R4/R8 result", sum_out, expq.pop_front());
      end
    end
  end

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, int gap);
    logic [OW-1:0] held;
    @(negedge clk);
    in_valid = 1'b1; a_in = a; b_in = b; c_in = c;
    expq.push_back(ref_sum(a, b, c, 1'b1));
    sent++;
    @(posedge clk); #1;
    check("R3 partial", sum_out, ref_sum(a, b, c, 1'b0));
    @(negedge clk);
    @(posedge clk); #1;
    held = sum_out;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_in = W'($urandom); b_in = W'($urandom); c_in = W'($urandom);
      @(posedge clk); #1;
      check("R7 hold", sum_out, held);
      check("R7 no pulse", OW'(sum_valid), '0);
    end
  endtask

  initial begin
    logic [W-1:0] mx, mn;
    void'($urandom(32'd20240517));
    mx = {1'b0, {(W-1){1'b1}}};
    mn = {1'b1, {(W-1){1'b0}}};
    rst_n = 1'b0; in_valid = 1'b0; a_in = '0; b_in = '0; c_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid low", OW'(sum_valid), '0);
    check("R1 sum zero", sum_out, '0);

    // R6 extremes
    send(mx, mx, mx, 1);
    send(mn, mn, mn, 1);
    send(mx, mn, W'(1), 0);
    send(W'(-1), W'(-1), W'(-1), 2);
    // R8 back-to-back directed run
    send(W'(5), W'(7), W'(-3), 0);
    send(W'(100), W'(-200), W'(50), 0);
    // R2 phase realigns after idle gaps of various length
    for (int i = 0; i < 400; i++) begin
      int gap;
      gap = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
      send(W'($urandom), W'($urandom), W'($urandom), gap);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    // R5 one pulse per sample
    check("R5 pulse count", OW'(seen), OW'(sent));
    check("R5 queue drained", OW'(expq.size()), '0);
    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule